// File: doc/BRIEF.md
# Registered 16-bit Arithmetic/Logic Unit with Operand Routing

This block is a 16-bit, three-bus arithmetic/logic unit. Two operand ports feed input registers. A two-bit route selector then chooses what reaches the two ALU inputs, called R and S. The choices are the A operand, the B operand, the stored result, or zero. A three-bit function code picks one of eight operations. The result goes into a result register, which drives the output port through an output enable. The three-state bus is modelled as a data-valid flag, with the data forced to zero while the port is disabled.

Each register has an active-low load enable. The A and B registers share one flow-through control, and the result register has its own. When a register is in flow-through, its input reaches its output combinationally. When route 00 is used with the add code, the block becomes an accumulator: each enabled clock edge adds A to the stored result. The MSB of the result then toggles at a rate set by A, which makes a programmable frequency divider. Carry-out, overflow and the group propagate/generate outputs allow the block to be cascaded through an external look-ahead carry unit. The zero flag reports whether the ALU result is all zeros.

Top module: `alu16_reg`

## Requirements
- R1: A synchronous active-high reset clears the A, B and result registers to 0x0000.
- R2: On a clock edge, the A register loads `a_in` when `a_load_n` is low and holds its value when it is high. The B register behaves the same way with `b_in` and `b_load_n`. While `opnd_bypass` is 1, the ALU sees `a_in`/`b_in` directly instead of the register contents.
- R3: `opsel` routes the ALU inputs as (R,S) as follows: 00 = (A, stored result), 01 = (A, B), 10 = (0, B), 11 = (A, 0). The S input under 00 is always the stored result register, never the flow-through value.
- R4: The arithmetic codes of `func` are: 011 = R+S+cin, 001 = S+~R+cin, 010 = R+~S+cin. With cin=1, codes 001 and 010 give true two's-complement subtraction.
- R5: The non-arithmetic codes of `func` are: 000 = all zeros, 100 = R XOR S, 101 = R OR S, 110 = R AND S, 111 = all ones.
- R6: On a clock edge, the result register loads the ALU result when `res_load_n` is low and holds when it is high. `f_out` shows the register when `res_bypass` is 0. It shows the same-cycle ALU result when `res_bypass` is 1.
- R7: When `out_en_n` is 1, `f_valid` is 0 and `f_out` is 0x0000. Otherwise `f_valid` is 1.
- R8: For the arithmetic codes, `carry_out` is bit 16 of the adder sum. `overflow` is the XOR of the carry into and the carry out of bit 15. For all other codes, both are 0.
- R9: `zero` is 1 exactly when the current ALU result, before the result register, is 0x0000.
- R10: For the arithmetic codes, let X and Y be the actual adder inputs. `grp_prop` is the AND over all bits of (X OR Y), and `grp_gen` is the carry out of X+Y with no carry-in, so `carry_out` equals `grp_gen | (grp_prop & carry_in)`. For all other codes, both are 0.
- R11: With route 00, code 011, cin 0 and `res_load_n` low, the stored result grows by A on every edge, wrapping modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | A operand |
| b_in | input | 16 | B operand |
| a_load_n | input | 1 | A register load, active low |
| b_load_n | input | 1 | B register load, active low |
| opnd_bypass | input | 1 | A and B flow-through when 1 |
| res_load_n | input | 1 | Result register load, active low |
| res_bypass | input | 1 | Result flow-through when 1 |
| out_en_n | input | 1 | Result port enable, active low |
| carry_in | input | 1 | Adder carry-in |
| func | input | 3 | Operation code |
| opsel | input | 2 | ALU input route |
| f_out | output | 16 | Result port (zero while disabled) |
| f_valid | output | 1 | Result port driven |
| carry_out | output | 1 | Adder carry out of bit 15 |
| overflow | output | 1 | Signed overflow |
| zero | output | 1 | ALU result is zero |
| grp_prop | output | 1 | Group propagate |
| grp_gen | output | 1 | Group generate |

## Verification
The feedback path reads the stored result, and the same clock edge can also overwrite that stored result. Route 00 with the add code and an open result load provokes this in every cycle of an accumulation. The bench starts the register near 0xFFFF so that the running sum wraps. It judges each edge by comparing `f_out` with the previous total plus A, and it checks that `carry_out` is high in the cycle before the wrap. A second case loads an operand register in the same cycle that its old contents are being used, and it confirms that the ALU switches to the new value only after the edge.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned GRP_W  = 4;
    localparam int unsigned N_GRP  = DATA_W / GRP_W;
    localparam int unsigned N_OPND = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        FN_CLEAR     = 3'b000,
        FN_S_MINUS_R = 3'b001,
        FN_R_MINUS_S = 3'b010,
        FN_ADD       = 3'b011,
        FN_XOR       = 3'b100,
        FN_OR        = 3'b101,
        FN_AND       = 3'b110,
        FN_PRESET    = 3'b111
    } func_e;

    typedef enum logic [1:0] {
        SEL_A_F = 2'b00,
        SEL_A_B = 2'b01,
        SEL_Z_B = 2'b10,
        SEL_A_Z = 2'b11
    } opsel_e;

    typedef struct packed {
        word_t r;
        word_t s;
    } operands_t;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic prop;
        logic gen;
    } flags_t;

    function automatic logic is_arith(input func_e fn);
        return (fn == FN_S_MINUS_R) || (fn == FN_R_MINUS_S) || (fn == FN_ADD);
    endfunction

    // Carry out of one nibble-wide group with no carry entering it.
    function automatic logic nib_gen(input logic [GRP_W-1:0] gx,
                                     input logic [GRP_W-1:0] gy);
        logic c;
        c = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            c = (gx[i] & gy[i]) | ((gx[i] | gy[i]) & c);
        end
        return c;
    endfunction

endpackage

// File: rtl/alu16_opreg.sv
module alu16_opreg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         bypass,
    input  logic [W-1:0] d,
    output logic [W-1:0] held,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (!load_n) begin
            held <= d;
        end
    end

    assign q = bypass ? d : held;

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
(
    input  func_e     fn,
    input  operands_t opnd,
    input  logic      cin,
    output word_t     res,
    output word_t     add_x,
    output word_t     add_y,
    output logic      arith,
    output logic      carry,
    output logic      ovf
);

    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W:0] sum;
    logic            c_into_msb;

    always_comb begin
        arith = is_arith(fn);
        add_x = opnd.r;
        add_y = opnd.s;
        case (fn)
            FN_S_MINUS_R: begin
                add_x = opnd.s;
                add_y = ~opnd.r;
            end
            FN_R_MINUS_S: begin
                add_x = opnd.r;
                add_y = ~opnd.s;
            end
            default: ;
        endcase
    end

    assign sum        = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, cin};
    assign c_into_msb = sum[MSB] ^ add_x[MSB] ^ add_y[MSB];

    always_comb begin
        case (fn)
            FN_CLEAR:     res = '0;
            FN_XOR:       res = opnd.r ^ opnd.s;
            FN_OR:        res = opnd.r | opnd.s;
            FN_AND:       res = opnd.r & opnd.s;
            FN_PRESET:    res = '1;
            default:      res = sum[MSB:0];
        endcase
    end

    assign carry = arith & sum[DATA_W];
    assign ovf   = arith & (sum[DATA_W] ^ c_into_msb);

endmodule

// File: rtl/alu16_lookahead.sv
module alu16_lookahead
    import alu16_pkg::*;
(
    input  word_t x,
    input  word_t y,
    input  logic  en,
    output logic  prop,
    output logic  gen
);

    logic [N_GRP-1:0] nib_p;
    logic [N_GRP-1:0] nib_g;
    logic             chain;

    for (genvar gi = 0; gi < N_GRP; gi++) begin : g_nib
        assign nib_p[gi] = &(x[gi*GRP_W +: GRP_W] | y[gi*GRP_W +: GRP_W]);
        assign nib_g[gi] = nib_gen(x[gi*GRP_W +: GRP_W], y[gi*GRP_W +: GRP_W]);
    end

    always_comb begin
        chain = 1'b0;
        for (int i = 0; i < N_GRP; i++) begin
            chain = nib_g[i] | (nib_p[i] & chain);
        end
    end

    assign gen  = en & chain;
    assign prop = en & (&nib_p);

endmodule

// File: rtl/alu16_reg.sv
module alu16_reg
    import alu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] a_in,
    input  logic [15:0] b_in,
    input  logic        a_load_n,
    input  logic        b_load_n,
    input  logic        opnd_bypass,
    input  logic        res_load_n,
    input  logic        res_bypass,
    input  logic        out_en_n,
    input  logic        carry_in,
    input  logic [2:0]  func,
    input  logic [1:0]  opsel,
    output logic [15:0] f_out,
    output logic        f_valid,
    output logic        carry_out,
    output logic        overflow,
    output logic        zero,
    output logic        grp_prop,
    output logic        grp_gen
);

    logic [N_OPND-1:0][DATA_W-1:0] op_d;
    logic [N_OPND-1:0][DATA_W-1:0] op_held;
    logic [N_OPND-1:0][DATA_W-1:0] op_q;
    logic [N_OPND-1:0]             op_load_n;

    word_t     a_held, b_held, a_q, b_q;
    word_t     f_held, f_q, alu_res;
    word_t     add_x, add_y;
    operands_t opnd;
    flags_t    flags;
    logic      arith;

    assign op_d      = {b_in, a_in};
    assign op_load_n = {b_load_n, a_load_n};

    for (genvar oi = 0; oi < N_OPND; oi++) begin : g_opnd
        alu16_opreg #(.W(DATA_W)) u_opreg (
            .clk    (clk),
            .rst    (rst),
            .load_n (op_load_n[oi]),
            .bypass (opnd_bypass),
            .d      (op_d[oi]),
            .held   (op_held[oi]),
            .q      (op_q[oi])
        );
    end

    assign a_held = op_held[0];
    assign b_held = op_held[1];
    assign a_q    = op_q[0];
    assign b_q    = op_q[1];

    // Feedback always taps the stored result, never the flow-through path.
    always_comb begin
        case (opsel_e'(opsel))
            SEL_A_F: opnd = '{r: a_q, s: f_held};
            SEL_A_B: opnd = '{r: a_q, s: b_q};
            SEL_Z_B: opnd = '{r: '0,  s: b_q};
            default: opnd = '{r: a_q, s: '0};
        endcase
    end

    alu16_core u_core (
        .fn    (func_e'(func)),
        .opnd  (opnd),
        .cin   (carry_in),
        .res   (alu_res),
        .add_x (add_x),
        .add_y (add_y),
        .arith (arith),
        .carry (flags.carry),
        .ovf   (flags.ovf)
    );

    alu16_lookahead u_cla (
        .x    (add_x),
        .y    (add_y),
        .en   (arith),
        .prop (flags.prop),
        .gen  (flags.gen)
    );

    assign flags.zero = (alu_res == '0);

    alu16_opreg #(.W(DATA_W)) u_freg (
        .clk    (clk),
        .rst    (rst),
        .load_n (res_load_n),
        .bypass (res_bypass),
        .d      (alu_res),
        .held   (f_held),
        .q      (f_q)
    );

    assign f_valid   = !out_en_n;
    assign f_out     = out_en_n ? '0 : f_q;
    assign carry_out = flags.carry;
    assign overflow  = flags.ovf;
    assign zero      = flags.zero;
    assign grp_prop  = flags.prop;
    assign grp_gen   = flags.gen;

endmodule

// File: rtl/alu16_reg_chk.sv
module alu16_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] a_in,
    input logic        a_load_n,
    input logic        res_load_n,
    input logic        res_bypass,
    input logic        out_en_n,
    input logic        carry_in,
    input logic [2:0]  func,
    input logic [15:0] f_out,
    input logic        f_valid,
    input logic        carry_out,
    input logic        overflow,
    input logic        zero,
    input logic        grp_prop,
    input logic        grp_gen,
    input logic [15:0] a_held,
    input logic [15:0] alu_res
);

    logic arith_code;
    assign arith_code = (func == 3'b001) || (func == 3'b010) || (func == 3'b011);

    // R2: A register holds when its load is inactive
    a_r2_a_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(a_load_n)) |-> (a_held == $past(a_held)));

    // R2: A register captures the port value when loaded
    a_r2_a_load: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!a_load_n)) |-> (a_held == $past(a_in)));

    // R6: stored result visible and unchanged when not loaded
    a_r6_f_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(res_load_n) && $past(!res_bypass) && $past(!out_en_n)
         && !res_bypass && !out_en_n) |-> (f_out == $past(f_out)));

    // R6: loaded result appears on the port after the edge
    a_r6_f_load: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!res_load_n) && !res_bypass && !out_en_n)
        |-> (f_out == $past(alu_res)));

    // R7: disabled port drives nothing
    a_r7_port_off: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (!f_valid && f_out == 16'h0000));

    // R10: look-ahead outputs agree with the adder carry
    a_r10_lookahead: assert property (@(posedge clk) disable iff (rst)
        arith_code |-> (carry_out == (grp_gen | (grp_prop & carry_in))));

    // R8: logic codes clear all arithmetic flags
    a_r8_logic_flags: assert property (@(posedge clk) disable iff (rst)
        !arith_code |-> (!carry_out && !overflow && !grp_prop && !grp_gen));

    // R5: clear code gives a zero result, preset never does
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (func == 3'b000) |-> zero);
    a_r5_preset_nonzero: assert property (@(posedge clk) disable iff (rst)
        (func == 3'b111) |-> !zero);

endmodule

bind alu16_reg alu16_reg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_load_n   (a_load_n),
    .res_load_n (res_load_n),
    .res_bypass (res_bypass),
    .out_en_n   (out_en_n),
    .carry_in   (carry_in),
    .func       (func),
    .f_out      (f_out),
    .f_valid    (f_valid),
    .carry_out  (carry_out),
    .overflow   (overflow),
    .zero       (zero),
    .grp_prop   (grp_prop),
    .grp_gen    (grp_gen),
    .a_held     (a_held),
    .alu_res    (alu_res)
);

// File: tb/alu16_reg_bench.sv
module alu16_reg_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] a_in, b_in;
    logic        a_load_n, b_load_n, opnd_bypass;
    logic        res_load_n, res_bypass, out_en_n, carry_in;
    logic [2:0]  func;
    logic [1:0]  opsel;
    logic [15:0] f_out;
    logic        f_valid, carry_out, overflow, zero, grp_prop, grp_gen;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    alu16_reg u_alu16_reg (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_load_n(a_load_n), .b_load_n(b_load_n), .opnd_bypass(opnd_bypass),
        .res_load_n(res_load_n), .res_bypass(res_bypass), .out_en_n(out_en_n),
        .carry_in(carry_in), .func(func), .opsel(opsel),
        .f_out(f_out), .f_valid(f_valid), .carry_out(carry_out),
        .overflow(overflow), .zero(zero), .grp_prop(grp_prop), .grp_gen(grp_gen)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {res[15:0], cout, ovf, zero, p, g}
    function automatic logic [20:0] model(input logic [2:0] fn, input logic [15:0] r,
                                          input logic [15:0] s, input logic cin);
        logic [15:0] x, y, res;
        logic [16:0] sm, raw;
        logic        ar, c15, co, ov, p, g;
        x = r; y = s;
        if (fn == 3'b001) begin x = s; y = ~r; end
        if (fn == 3'b010) begin x = r; y = ~s; end
        ar  = (fn == 3'b001) || (fn == 3'b010) || (fn == 3'b011);
        sm  = {1'b0, x} + {1'b0, y} + {16'h0, cin};
        raw = {1'b0, x} + {1'b0, y};
        c15 = sm[15] ^ x[15] ^ y[15];
        case (fn)
            3'b000:  res = 16'h0000;
            3'b100:  res = r ^ s;
            3'b101:  res = r | s;
            3'b110:  res = r & s;
            3'b111:  res = 16'hFFFF;
            default: res = sm[15:0];
        endcase
        co = ar & sm[16];
        ov = ar & (sm[16] ^ c15);
        p  = ar & (&(x | y));
        g  = ar & raw[16];
        return {res, co, ov, (res == 16'h0000), p, g};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic defaults();
        a_in = 16'h0; b_in = 16'h0;
        a_load_n = 1'b1; b_load_n = 1'b1; opnd_bypass = 1'b0;
        res_load_n = 1'b1; res_bypass = 1'b0; out_en_n = 1'b0;
        carry_in = 1'b0; func = 3'b011; opsel = 2'b01;
    endtask

    task automatic t_reset();
        defaults();
        a_in = 16'h5555; b_in = 16'hAAAA;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        chk("R1 stored result after reset", {16'h0, f_out}, 32'h0);
        res_bypass = 1'b1;
        #1;
        chk("R1 A+B of cleared registers", {16'h0, f_out}, 32'h0);
        chk("R9 zero flag on zero sum", {31'h0, zero}, 32'h1);
        res_bypass = 1'b0;
    endtask

    task automatic t_functions();
        logic [15:0] pr [6];
        logic [15:0] ps [6];
        pr = '{16'h1234, 16'h7FFF, 16'hFFFF, 16'h8000, 16'h0000, 16'hA5A5};
        ps = '{16'h0FED, 16'h0001, 16'h0001, 16'h8000, 16'h0000, 16'h5A5A};
        defaults();
        opnd_bypass = 1'b1; res_bypass = 1'b1; opsel = 2'b01;
        for (int k = 0; k < 6; k++) begin
            for (int f = 0; f < 8; f++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [20:0] m;
                    a_in = pr[k]; b_in = ps[k]; func = f[2:0]; carry_in = c[0];
                    #1;
                    m = model(f[2:0], pr[k], ps[k], c[0]);
                    if (f == 1 || f == 2 || f == 3)
                        chk("R4 arithmetic result", {16'h0, f_out}, {16'h0, m[20:5]});
                    else
                        chk("R5 logic result", {16'h0, f_out}, {16'h0, m[20:5]});
                    chk("R8 carry_out", {31'h0, carry_out}, {31'h0, m[4]});
                    chk("R8 overflow", {31'h0, overflow}, {31'h0, m[3]});
                    chk("R9 zero", {31'h0, zero}, {31'h0, m[2]});
                    chk("R10 propagate", {31'h0, grp_prop}, {31'h0, m[1]});
                    chk("R10 generate", {31'h0, grp_gen}, {31'h0, m[0]});
                end
            end
        end
        // Directed corners
        func = 3'b011; carry_in = 1'b0; a_in = 16'h7FFF; b_in = 16'h0001; #1;
        chk("R8 signed overflow 7FFF+1", {30'h0, carry_out, overflow}, 32'h1);
        a_in = 16'hFFFF; #1;
        chk("R8 carry FFFF+1", {30'h0, carry_out, overflow}, 32'h2);
        chk("R9 zero on wrap", {31'h0, zero}, 32'h1);
        func = 3'b010; carry_in = 1'b1; a_in = 16'h0005; b_in = 16'h0007; #1;
        chk("R4 R minus S two's complement", {16'h0, f_out}, 32'hFFFE);
        func = 3'b001; #1;
        chk("R4 S minus R two's complement", {16'h0, f_out}, 32'h0002);
    endtask

    task automatic t_opsel();
        defaults();
        opnd_bypass = 1'b1;
        a_in = 16'h1234; b_in = 16'h0000; res_load_n = 1'b0;
        tick();
        res_load_n = 1'b1; res_bypass = 1'b1;
        a_in = 16'h0101; b_in = 16'h2000;
        opsel = 2'b00; #1;
        chk("R3 route 00 A plus stored F", {16'h0, f_out}, 32'h1335);
        opsel = 2'b10; #1;
        chk("R3 route 10 zero plus B", {16'h0, f_out}, 32'h2000);
        opsel = 2'b11; #1;
        chk("R3 route 11 A plus zero", {16'h0, f_out}, 32'h0101);
        opsel = 2'b01; #1;
        chk("R3 route 01 A plus B", {16'h0, f_out}, 32'h2101);
    endtask

    task automatic t_opreg();
        defaults();
        opnd_bypass = 1'b0; res_bypass = 1'b1;
        a_in = 16'h00FF; b_in = 16'h0F00; a_load_n = 1'b0; b_load_n = 1'b0;
        #1;
        chk("R2 old contents used before edge", {16'h0, f_out}, 32'h0000);
        tick();
        a_load_n = 1'b1; b_load_n = 1'b1;
        a_in = 16'h1111; b_in = 16'h2222;
        #1;
        chk("R2 registers loaded", {16'h0, f_out}, 32'h0FFF);
        tick();
        chk("R2 registers held", {16'h0, f_out}, 32'h0FFF);
        a_load_n = 1'b0;
        tick();
        a_load_n = 1'b1;
        #1;
        chk("R2 only A reloaded", {16'h0, f_out}, 32'h2011);
        opnd_bypass = 1'b1; #1;
        chk("R2 operand flow-through", {16'h0, f_out}, 32'h3333);
    endtask

    task automatic t_freg();
        defaults();
        opnd_bypass = 1'b1;
        a_in = 16'h4321; b_in = 16'h0000; res_load_n = 1'b0;
        tick();
        chk("R6 result loaded", {16'h0, f_out}, 32'h4321);
        res_load_n = 1'b1; a_in = 16'h9999;
        tick();
        chk("R6 result held", {16'h0, f_out}, 32'h4321);
        res_bypass = 1'b1; #1;
        chk("R6 result flow-through", {16'h0, f_out}, 32'h9999);
        res_bypass = 1'b0; #1;
        chk("R6 register kept under flow-through", {16'h0, f_out}, 32'h4321);
    endtask

    task automatic t_port();
        defaults();
        out_en_n = 1'b1; #1;
        chk("R7 port disabled data", {16'h0, f_out}, 32'h0);
        chk("R7 port disabled valid", {31'h0, f_valid}, 32'h0);
        out_en_n = 1'b0; #1;
        chk("R7 port enabled valid", {31'h0, f_valid}, 32'h1);
        chk("R7 port enabled data", {16'h0, f_out}, 32'h4321);
    endtask

    task automatic t_accum();
        logic [15:0] total;
        defaults();
        opnd_bypass = 1'b1; opsel = 2'b10; b_in = 16'hFFF8; res_load_n = 1'b0;
        tick();
        total = 16'hFFF8;
        opsel = 2'b00; a_in = 16'h0003; func = 3'b011;
        for (int k = 0; k < 6; k++) begin
            #1;
            if (k == 2)
                chk("R11 carry before wrap", {31'h0, carry_out}, 32'h1);
            tick();
            total = total + 16'h0003;
            chk("R11 accumulated total", {16'h0, f_out}, {16'h0, total});
        end
        res_load_n = 1'b1;
        tick();
        chk("R11 accumulation paused", {16'h0, f_out}, {16'h0, total});
    endtask

    initial begin
        #(8 * 100000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        defaults();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_functions();
        t_opsel();
        t_opreg();
        t_freg();
        t_port();
        t_accum();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule